// File: doc/BRIEF.md
# DDR Power-Up Command Sequencer

This block walks a DDR1 or DDR2 memory device through its power-up programming once a start pulse arrives. Two strap inputs are captured at start: one picks the memory generation, the other says whether the reference clock runs at 40 MHz or 25 MHz. The block then plays a fixed list of steps toward a memory-controller command port. Each step presents a target register code, a data word and a one-hot command strobe. A step that only loads a register carries an all-zero strobe.

Every step is held on the port until the controller acknowledges it. The next step appears on the following clock. Both lists begin by programming the bus timeout and end by programming the refresh control, the two DQS lane taps and the read-cycle register. After the final acknowledge the block raises done and keeps it high until it is started again.

Top module: `ddr_init_seq`

## Requirements
- R1: While rst_n is low at a clock edge, the block goes idle on that edge: cmd_req, cmd_strobe, busy and done are all zero afterwards.
- R2: A start pulse seen while not busy raises busy and cmd_req on the next clock. The first step presented is target 1 (bus timeout) with data 0xFFFFF and a zero strobe.
- R3: cmd_strobe has at most one bit set, and only while cmd_req is high. The bit meanings are: bit0 mode set (target 3), bit1 extended mode set (target 4), bit2 auto refresh, bit3 precharge all, bit4 extended mode 2 set (target 5), bit5 extended mode 3 set (target 6). Precharge and refresh carry target 0 and data 0.
- R4: With strap_ddr2 high, the steps after the timeout are as follows, in this order:
  - DDR2 configuration (target 2) 0xA59: tWL 2 in bits 13:10, ODT at bit 9, tFAW 22 in bits 7:2, enable at bit 0.
  - Precharge.
  - Extended mode 2 set with 0, then extended mode 3 set with 0, then extended mode set with 0.
  - Mode set with 0x100.
  - Precharge, then two auto refreshes.
  - Mode set with 0xA33.
  - Extended mode set with 0x382, then extended mode set with 0x402.
- R5: With strap_ddr2 low, the steps after the timeout are as follows, in this order:
  - Precharge.
  - Mode set with 0x133.
  - Extended mode set with 0x02.
  - Precharge.
  - Mode set with 0x33.
- R6: After the command steps, the refresh word goes to target 7. It has an enable at bit 14 and an interval count in bits 9:0: 624 (0x4270) when strap_ref40 was high at start, otherwise 390 (0x4186).
- R7: The last three steps write 0x08 to target 8 (lane 0 tap), 0x09 to target 9 (lane 1 tap) and 0xFF to target 10 (read cycle).
- R8: While cmd_req is high and cmd_ack is low, cmd_strobe, reg_tgt and reg_data hold their values. The step after an acknowledged one is presented on the next clock.
- R9: A start pulse or a strap change while busy has no effect on the running sequence.
- R10: After the last step is acknowledged, done is high and cmd_req and busy are low on the next clock. done stays high until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin the sequence (honoured when not busy) |
| strap_ddr2 | input | 1 | 1 selects the DDR2 list, 0 the DDR1 list |
| strap_ref40 | input | 1 | 1 selects the 40 MHz refresh count, 0 the 25 MHz one |
| cmd_ack | input | 1 | Controller accepts the presented step |
| cmd_req | output | 1 | A step is being presented |
| cmd_strobe | output | 6 | One-hot command strobe |
| reg_tgt | output | 4 | Target register code |
| reg_data | output | 32 | Data word for the target register |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished |

## Verification
A wrong step index or a mis-latched strap shows on reg_tgt, reg_data or cmd_strobe as soon as the affected step is presented. That is at most one clock after the preceding acknowledge, so each step is compared the moment it appears. A controller that lost track of its state would drop cmd_req early, hold done low, or change the presented fields while no acknowledge is given. Holding the acknowledge off for several cycles exposes that at once. Starting again while busy would show on the next presented step as a jump back to the timeout write.

// File: rtl/ddr_init_pkg.sv
// Package: shared codes, widths and step record for the DDR power-up sequencer.
// Assumes: targets are numbered by the controller's register decoder.
package ddr_init_pkg;
    localparam int CMD_W  = 6;
    localparam int TGT_W  = 4;
    localparam int DATA_W = 32;

    // one-hot command strobe bit positions
    localparam int B_MRS   = 0;
    localparam int B_EMRS  = 1;
    localparam int B_AREF  = 2;
    localparam int B_PREA  = 3;
    localparam int B_EMRS2 = 4;
    localparam int B_EMRS3 = 5;

    typedef enum logic [TGT_W-1:0] {
        T_NONE   = 4'd0,
        T_TMO    = 4'd1,
        T_CFG2   = 4'd2,
        T_MODE   = 4'd3,
        T_EXT    = 4'd4,
        T_EXT2   = 4'd5,
        T_EXT3   = 4'd6,
        T_REFR   = 4'd7,
        T_TAP0   = 4'd8,
        T_TAP1   = 4'd9,
        T_RDCYC  = 4'd10
    } tgt_e;

    typedef struct packed {
        logic [CMD_W-1:0]  cmd;
        logic [TGT_W-1:0]  tgt;
        logic [DATA_W-1:0] data;
    } step_t;

    localparam int DDR2_STEPS = 17;
    localparam int DDR1_STEPS = 10;
    localparam int MAX_STEPS  = (DDR2_STEPS > DDR1_STEPS) ? DDR2_STEPS : DDR1_STEPS;
    localparam int IDX_W      = $clog2(MAX_STEPS);

    function automatic step_t mk(input int cbit, input tgt_e t, input logic [DATA_W-1:0] d);
        step_t s;
        s.cmd  = (cbit < 0) ? '0 : CMD_W'(1 << cbit);
        s.tgt  = t;
        s.data = d;
        return s;
    endfunction
endpackage

// File: rtl/ddr_init_step_rom.sv
// Step decoder: maps (memory type, reference select, step index) to the step
// record. Purely combinational. Assumes idx never exceeds the list length.
module ddr_init_step_rom
    import ddr_init_pkg::*;
#(
    parameter int REF_CNT_40 = 624,
    parameter int REF_CNT_25 = 390,
    parameter int REF_EN_BIT = 14,
    parameter int REF_CNT_W  = 10
) (
    input  logic             is_ddr2,
    input  logic             ref40,
    input  logic [IDX_W-1:0] idx,
    output step_t            step,
    output logic             last
);
    localparam logic [DATA_W-1:0] TMO_VAL   = 32'h000F_FFFF;
    localparam logic [DATA_W-1:0] CFG2_VAL  = (32'd2 << 10) | (32'd1 << 9) | (32'd22 << 2) | 32'd1;
    localparam logic [DATA_W-1:0] REF_EN    = 32'd1 << REF_EN_BIT;
    localparam logic [DATA_W-1:0] CNT_MASK  = (32'd1 << REF_CNT_W) - 32'd1;
    localparam logic [DATA_W-1:0] REF40_VAL = REF_EN | (REF_CNT_40 & CNT_MASK);
    localparam logic [DATA_W-1:0] REF25_VAL = REF_EN | (REF_CNT_25 & CNT_MASK);

    logic [DATA_W-1:0] ref_word;

    // refresh word chosen by the captured reference select
    always_comb ref_word = ref40 ? REF40_VAL : REF25_VAL;

    // step lookup for both memory generations
    always_comb begin
        step = '0;
        if (is_ddr2) begin
            case (idx)
                5'd0:  step = mk(-1,      T_TMO,  TMO_VAL);
                5'd1:  step = mk(-1,      T_CFG2, CFG2_VAL);
                5'd2:  step = mk(B_PREA,  T_NONE, '0);
                5'd3:  step = mk(B_EMRS2, T_EXT2, '0);
                5'd4:  step = mk(B_EMRS3, T_EXT3, '0);
                5'd5:  step = mk(B_EMRS,  T_EXT,  '0);
                5'd6:  step = mk(B_MRS,   T_MODE, 32'h100);
                5'd7:  step = mk(B_PREA,  T_NONE, '0);
                5'd8:  step = mk(B_AREF,  T_NONE, '0);
                5'd9:  step = mk(B_AREF,  T_NONE, '0);
                5'd10: step = mk(B_MRS,   T_MODE, 32'hA33);
                5'd11: step = mk(B_EMRS,  T_EXT,  32'h382);
                5'd12: step = mk(B_EMRS,  T_EXT,  32'h402);
                5'd13: step = mk(-1,      T_REFR, ref_word);
                5'd14: step = mk(-1,      T_TAP0, 32'h08);
                5'd15: step = mk(-1,      T_TAP1, 32'h09);
                5'd16: step = mk(-1,      T_RDCYC, 32'hFF);
                default: step = '0;
            endcase
        end else begin
            case (idx)
                5'd0:  step = mk(-1,      T_TMO,  TMO_VAL);
                5'd1:  step = mk(B_PREA,  T_NONE, '0);
                5'd2:  step = mk(B_MRS,   T_MODE, 32'h133);
                5'd3:  step = mk(B_EMRS,  T_EXT,  32'h02);
                5'd4:  step = mk(B_PREA,  T_NONE, '0);
                5'd5:  step = mk(B_MRS,   T_MODE, 32'h33);
                5'd6:  step = mk(-1,      T_REFR, ref_word);
                5'd7:  step = mk(-1,      T_TAP0, 32'h08);
                5'd8:  step = mk(-1,      T_TAP1, 32'h09);
                5'd9:  step = mk(-1,      T_RDCYC, 32'hFF);
                default: step = '0;
            endcase
        end
    end

    // final-step flag per list length
    always_comb last = is_ddr2 ? (idx == IDX_W'(DDR2_STEPS - 1)) : (idx == IDX_W'(DDR1_STEPS - 1));
endmodule

// File: rtl/ddr_init_seq_ctrl.sv
// Sequencer control: idle/run/finished state, step index and strap capture.
// Assumes cmd_ack is only meaningful while a step is presented.
module ddr_init_seq_ctrl
    import ddr_init_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             strap_ddr2,
    input  logic             strap_ref40,
    input  logic             ack,
    input  logic             last,
    output logic [IDX_W-1:0] idx,
    output logic             ddr2_q,
    output logic             ref40_q,
    output logic             running,
    output logic             finished
);
    typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} st_e;
    st_e state;

    // state, index and strap capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            idx     <= '0;
            ddr2_q  <= 1'b0;
            ref40_q <= 1'b0;
        end else begin
            case (state)
                S_IDLE, S_DONE: begin
                    if (start) begin
                        state   <= S_RUN;
                        idx     <= '0;
                        ddr2_q  <= strap_ddr2;
                        ref40_q <= strap_ref40;
                    end
                end
                S_RUN: begin
                    if (ack) begin
                        if (last) state <= S_DONE;
                        else      idx   <= idx + 1'b1;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // status decode
    always_comb begin
        running  = (state == S_RUN);
        finished = (state == S_DONE);
    end
endmodule

// File: rtl/ddr_init_seq.sv
// Top: DDR power-up command sequencer. Presents one step at a time to a
// controller command port and advances on acknowledge.
// Assumes the controller decodes reg_tgt and applies cmd_strobe itself.
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int REF_CNT_40 = 624,
    parameter int REF_CNT_25 = 390
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              strap_ddr2,
    input  logic              strap_ref40,
    input  logic              cmd_ack,
    output logic              cmd_req,
    output logic [CMD_W-1:0]  cmd_strobe,
    output logic [TGT_W-1:0]  reg_tgt,
    output logic [DATA_W-1:0] reg_data,
    output logic              busy,
    output logic              done
);
    logic [IDX_W-1:0] idx;
    logic             ddr2_q, ref40_q, running, finished, last;
    step_t            step;

    ddr_init_seq_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .strap_ddr2  (strap_ddr2),
        .strap_ref40 (strap_ref40),
        .ack         (cmd_ack),
        .last        (last),
        .idx         (idx),
        .ddr2_q      (ddr2_q),
        .ref40_q     (ref40_q),
        .running     (running),
        .finished    (finished)
    );

    ddr_init_step_rom #(
        .REF_CNT_40 (REF_CNT_40),
        .REF_CNT_25 (REF_CNT_25)
    ) u_rom (
        .is_ddr2 (ddr2_q),
        .ref40   (ref40_q),
        .idx     (idx),
        .step    (step),
        .last    (last)
    );

    // port drive: fields are zero whenever no step is presented
    always_comb begin
        cmd_req    = running;
        cmd_strobe = running ? step.cmd  : '0;
        reg_tgt    = running ? step.tgt  : '0;
        reg_data   = running ? step.data : '0;
        busy       = running;
        done       = finished;
    end
endmodule

// File: rtl/ddr_init_seq_checker.sv
// Checker: protocol properties of the sequencer ports, bound to the top.
module ddr_init_seq_checker
    import ddr_init_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              cmd_ack,
    input logic              cmd_req,
    input logic [CMD_W-1:0]  cmd_strobe,
    input logic [TGT_W-1:0]  reg_tgt,
    input logic [DATA_W-1:0] reg_data,
    input logic              busy,
    input logic              done
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!cmd_req && !busy && !done && cmd_strobe == '0));

    assert_start_runs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (cmd_req && busy));

    assert_strobe_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_strobe) && (cmd_strobe == '0 || cmd_req));

    assert_hold_until_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && !cmd_ack) |=> (cmd_req && $stable(cmd_strobe) && $stable(reg_tgt) && $stable(reg_data)));

    assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!cmd_req && !busy));

    assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);
endmodule

bind ddr_init_seq ddr_init_seq_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cmd_ack    (cmd_ack),
    .cmd_req    (cmd_req),
    .cmd_strobe (cmd_strobe),
    .reg_tgt    (reg_tgt),
    .reg_data   (reg_data),
    .busy       (busy),
    .done       (done)
);

// File: tb/ddr_init_seq_test.sv
module ddr_init_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        strap_ddr2 = 1'b0;
    logic        strap_ref40 = 1'b0;
    logic        cmd_ack = 1'b0;
    logic        cmd_req;
    logic [5:0]  cmd_strobe;
    logic [3:0]  reg_tgt;
    logic [31:0] reg_data;
    logic        busy, done;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    ddr_init_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .strap_ddr2(strap_ddr2),
        .strap_ref40(strap_ref40), .cmd_ack(cmd_ack), .cmd_req(cmd_req),
        .cmd_strobe(cmd_strobe), .reg_tgt(reg_tgt), .reg_data(reg_data),
        .busy(busy), .done(done)
    );

    localparam logic [5:0] NO = 6'b000000, MR = 6'b000001, EM = 6'b000010,
                           AR = 6'b000100, PR = 6'b001000, E2 = 6'b010000, E3 = 6'b100000;

    // expected steps {strobe, target, data}: DDR2 list 0..16, DDR1 list 17..26
    localparam logic [41:0] EXP [27] = '{
        {NO, 4'd1, 32'hFFFFF}, {NO, 4'd2, 32'hA59}, {PR, 4'd0, 32'h0},
        {E2, 4'd5, 32'h0}, {E3, 4'd6, 32'h0}, {EM, 4'd4, 32'h0},
        {MR, 4'd3, 32'h100}, {PR, 4'd0, 32'h0}, {AR, 4'd0, 32'h0},
        {AR, 4'd0, 32'h0}, {MR, 4'd3, 32'hA33}, {EM, 4'd4, 32'h382},
        {EM, 4'd4, 32'h402}, {NO, 4'd7, 32'h4186}, {NO, 4'd8, 32'h08},
        {NO, 4'd9, 32'h09}, {NO, 4'd10, 32'hFF},
        {NO, 4'd1, 32'hFFFFF}, {PR, 4'd0, 32'h0}, {MR, 4'd3, 32'h133},
        {EM, 4'd4, 32'h02}, {PR, 4'd0, 32'h0}, {MR, 4'd3, 32'h33},
        {NO, 4'd7, 32'h4186}, {NO, 4'd8, 32'h08}, {NO, 4'd9, 32'h09},
        {NO, 4'd10, 32'hFF}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // run one full sequence; busy_poke pulses start and flips straps mid-run
    task automatic run_seq(input logic ddr2, input logic ref40, input logic busy_poke);
        int base = ddr2 ? 0 : 17;
        int n    = ddr2 ? 17 : 10;
        strap_ddr2 = ddr2;
        strap_ref40 = ref40;
        @(negedge clk);
        pulse_start();
        check("R2 busy after start", {63'd0, busy}, 64'd1);
        for (int i = 0; i < n; i++) begin
            logic [41:0] e = EXP[base + i];
            logic [41:0] got;
            string tag;
            if (e[35:32] == 4'd7) e[31:0] = ref40 ? 32'h4270 : 32'h4186;
            if (i == 0) tag = "R2";
            else if (e[35:32] == 4'd7) tag = "R6";
            else if (e[35:32] >= 4'd8) tag = "R7";
            else tag = ddr2 ? "R4" : "R5";
            got = {cmd_strobe, reg_tgt, reg_data};
            check({tag, " step"}, {22'd0, got}, {22'd0, e});
            check("R3 req with step", {63'd0, cmd_req}, 64'd1);
            for (int h = 0; h < (i % 3); h++) begin
                if (busy_poke && i == 4 && h == 0) begin
                    strap_ddr2 = ~ddr2;
                    strap_ref40 = ~ref40;
                    pulse_start();
                end else begin
                    @(negedge clk);
                end
                check("R8 hold", {22'd0, cmd_strobe, reg_tgt, reg_data}, {22'd0, e});
            end
            cmd_ack = 1'b1;
            @(negedge clk);
            cmd_ack = 1'b0;
        end
        check("R10 done", {61'd0, done, busy, cmd_req}, 64'b100);
        for (int k = 0; k < 4; k++) @(negedge clk);
        check("R10 done held", {61'd0, done, busy, cmd_req}, 64'b100);
    endtask

    initial begin
        #(20 * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        check("R1 reset", {28'd0, cmd_req, busy, done, cmd_strobe, reg_tgt, 22'd0}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle", {61'd0, cmd_req, busy, done}, 64'd0);

        // table-driven runs, one per strap combination
        run_seq(1'b1, 1'b1, 1'b0);
        run_seq(1'b1, 1'b0, 1'b1);
        run_seq(1'b0, 1'b1, 1'b1);
        run_seq(1'b0, 1'b0, 1'b0);

        // R9: a start while busy must not restart; the second step follows the first
        strap_ddr2 = 1'b0;
        pulse_start();
        cmd_ack = 1'b1;
        @(negedge clk);
        cmd_ack = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R9 no restart", {54'd0, cmd_strobe, reg_tgt}, {54'd0, PR, 4'd0});

        // R1: reset in the middle of a run returns to idle
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset", {55'd0, cmd_req, busy, done, cmd_strobe}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 stays idle", {61'd0, cmd_req, busy, done}, 64'd0);

        // R8: acknowledge while idle has no effect
        cmd_ack = 1'b1;
        @(negedge clk);
        cmd_ack = 1'b0;
        check("R8 idle ack", {61'd0, cmd_req, busy, done}, 64'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule